// File: doc/BRIEF.md
# Accumulator ALU with Status Flag Generation

This block is the byte-wide arithmetic and logic unit of an accumulator-style processor. Each request carries an operation code, the target value (the accumulator, an index register or a memory byte, routed in by the caller), the second operand, the high byte of the accumulator, the incoming carry and an immediate-mode qualifier. The block returns the result, a second result byte for the exchange operation, the negative, overflow, zero and carry flags, and a four-bit update mask. A status register downstream changes only the flags whose mask bit is set. A write-enable tells the caller whether the result goes back to its destination.

Requests enter on a valid/ready channel. Results leave on a second valid/ready channel through one register stage. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or the consumer is taking its contents in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value, and no new request is taken. Arithmetic is always binary. Decimal correction is outside this block.

Top module: `acc_alu`

## Requirements
- R1: A request accepted on a clock edge appears on the outputs, with `out_valid` high, after that same edge. While `out_valid` is high and `out_ready` is low, all outputs hold their values and `in_ready` is low.
- R2: Op 1 (add) gives target + operand + carry. Op 2 (subtract) gives target + ~operand + carry, where carry set means no borrow. Both drive carry-out, signed overflow, N = result bit 7 and Z = (result == 0). Both use mask 4'b1111 and write-enable 1.
- R3: Ops 3, 4 and 5 give target AND, XOR and OR operand. They set N and Z from the result, use mask 4'b1010 and write-enable 1.
- R4: Op 6 shifts left with 0 in and op 7 shifts right with 0 in. Op 8 rotates left and op 9 rotates right, each with the incoming carry moved into the vacated bit. The bit shifted out becomes C. N and Z come from the result. Mask 4'b1011, write-enable 1.
- R5: Op 10 (bit test) sets Z when target AND operand is zero, with write-enable 0. It copies operand bits 7 and 6 into N and V with mask 4'b1110. When `in_imm` is 1, the mask is 4'b0010 and N and V read 0.
- R6: Op 14 returns operand OR target and op 15 returns operand AND NOT target. In both, Z reflects target AND operand as it was before the change. Mask 4'b0010, write-enable 1.
- R7: Op 11 (compare) computes target + ~operand + 1, sets N, Z and C from it, uses mask 4'b1011 and write-enable 0.
- R8: Op 12 returns target + 1 and op 13 returns target - 1, both modulo 256. N and Z come from the result. Mask 4'b1010, write-enable 1.
- R9: Op 16 swaps the bytes. `out_res` is the old high byte, `out_res_hi` is the old target byte, and N and Z come from the new `out_res`. Mask 4'b1010, write-enable 1. Every other op passes `in_acc_hi` through to `out_res_hi` unchanged.
- R10: Op 0 and the unused codes 17 to 31 return the target unchanged, with mask 0 and write-enable 0. For every op, a flag whose mask bit is clear reads 0. The mask order is {N,V,Z,C}, with N in bit 3.
- R11: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_op | input | 5 | Operation code |
| in_acc | input | 8 | Target value (accumulator, index register or memory byte) |
| in_acc_hi | input | 8 | High byte of the accumulator |
| in_opnd | input | 8 | Second operand (memory or immediate) |
| in_carry | input | 1 | Incoming carry flag |
| in_imm | input | 1 | Immediate-mode qualifier |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 8 | Result byte |
| out_res_hi | output | 8 | High result byte |
| out_n | output | 1 | Negative flag |
| out_v | output | 1 | Overflow flag |
| out_z | output | 1 | Zero flag |
| out_c | output | 1 | Carry flag |
| out_mask | output | 4 | Flag update enables {N,V,Z,C} |
| out_wr | output | 1 | Result is to be written back |

## Verification
The hardest case to bring about is a held output that must stay unchanged while a different request waits at the input. That request may be a bit test whose immediate qualifier narrows the mask. The bench reaches it by lowering `out_ready` at random while `in_valid` and the operands keep changing. It compares every output on every cycle against the oldest unconsumed expected entry. A directed prologue first hits the overflow and carry boundaries (0x7F+1, 0xFF+1, 0x80-1), an equal compare, a rotate carrying through, both bit-test modes and an exchange that yields zero.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W   = 5;
  localparam int FLAG_N = 3;
  localparam int FLAG_V = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 5'd0,
    OP_ADC = 5'd1,
    OP_SBC = 5'd2,
    OP_AND = 5'd3,
    OP_EOR = 5'd4,
    OP_ORA = 5'd5,
    OP_ASL = 5'd6,
    OP_LSR = 5'd7,
    OP_ROL = 5'd8,
    OP_ROR = 5'd9,
    OP_BIT = 5'd10,
    OP_CMP = 5'd11,
    OP_INC = 5'd12,
    OP_DEC = 5'd13,
    OP_TSB = 5'd14,
    OP_TRB = 5'd15,
    OP_XBA = 5'd16
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int SW = W + 1;

  logic [W-1:0]  bop;
  logic          bcin;
  logic [SW-1:0] wide;

  // One adder serves add, subtract, compare, increment and decrement.
  always_comb begin
    bop  = '0;
    bcin = 1'b0;
    case (op)
      OP_ADC: begin bop = m;  bcin = cin;  end
      OP_SBC: begin bop = ~m; bcin = cin;  end
      OP_CMP: begin bop = ~m; bcin = 1'b1; end
      OP_INC: begin bop = '0; bcin = 1'b1; end
      OP_DEC: begin bop = '1; bcin = 1'b0; end
      default: ;
    endcase
  end

  assign wide = {1'b0, a} + {1'b0, bop} + {{W{1'b0}}, bcin};
  assign sum  = wide[W-1:0];
  assign cout = wide[W];
  assign ovf  = (a[W-1] == bop[W-1]) && (wide[W-1] != a[W-1]);

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  output logic [W-1:0] lres,
  output logic         and_zero,
  output logic         top_bit,
  output logic         next_bit
);
  logic [W-1:0] and_v, eor_v, or_v, clr_v;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_v[i] = a[i] & m[i];
    assign eor_v[i] = a[i] ^ m[i];
    assign or_v[i]  = a[i] | m[i];
    assign clr_v[i] = m[i] & ~a[i];
  end

  always_comb begin
    case (op)
      OP_AND:  lres = and_v;
      OP_EOR:  lres = eor_v;
      OP_ORA:  lres = or_v;
      OP_TSB:  lres = or_v;
      OP_TRB:  lres = clr_v;
      default: lres = a;
    endcase
  end

  assign and_zero = ~|and_v;
  assign top_bit  = m[W-1];
  assign next_bit = m[W-2];

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] hi,
  input  logic         cin,
  output logic [W-1:0] sres,
  output logic [W-1:0] shi,
  output logic         sc
);
  always_comb begin
    sres = a;
    shi  = hi;
    sc   = 1'b0;
    case (op)
      OP_ASL: begin sres = {a[W-2:0], 1'b0}; sc = a[W-1]; end
      OP_LSR: begin sres = {1'b0, a[W-1:1]}; sc = a[0];   end
      OP_ROL: begin sres = {a[W-2:0], cin};  sc = a[W-1]; end
      OP_ROR: begin sres = {cin, a[W-1:1]};  sc = a[0];   end
      OP_XBA: begin sres = hi; shi = a; end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic         imm,
  input  logic [W-1:0] a,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] sum,
  input  logic         cout,
  input  logic         ovf,
  input  logic [W-1:0] lres,
  input  logic         and_zero,
  input  logic         top_bit,
  input  logic         next_bit,
  input  logic [W-1:0] sres,
  input  logic [W-1:0] shi,
  input  logic         sc,
  output logic [W-1:0] res,
  output logic [W-1:0] res_hi,
  output flags_t       flg,
  output logic [3:0]   mask,
  output logic         wr
);
  always_comb begin
    res    = a;
    res_hi = hi;
    flg    = '0;
    mask   = 4'b0000;
    wr     = 1'b0;
    case (op)
      OP_ADC, OP_SBC: begin
        res = sum; wr = 1'b1; mask = 4'b1111;
        flg = '{n: sum[W-1], v: ovf, z: (sum == '0), c: cout};
      end
      OP_CMP: begin
        res = sum; mask = 4'b1011;
        flg = '{n: sum[W-1], v: 1'b0, z: (sum == '0), c: cout};
      end
      OP_INC, OP_DEC: begin
        res = sum; wr = 1'b1; mask = 4'b1010;
        flg = '{n: sum[W-1], v: 1'b0, z: (sum == '0), c: 1'b0};
      end
      OP_AND, OP_EOR, OP_ORA: begin
        res = lres; wr = 1'b1; mask = 4'b1010;
        flg = '{n: lres[W-1], v: 1'b0, z: (lres == '0), c: 1'b0};
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res = sres; wr = 1'b1; mask = 4'b1011;
        flg = '{n: sres[W-1], v: 1'b0, z: (sres == '0), c: sc};
      end
      OP_XBA: begin
        res = sres; res_hi = shi; wr = 1'b1; mask = 4'b1010;
        flg = '{n: sres[W-1], v: 1'b0, z: (sres == '0), c: 1'b0};
      end
      OP_BIT: begin
        if (imm) begin
          mask = 4'b0010;
          flg  = '{n: 1'b0, v: 1'b0, z: and_zero, c: 1'b0};
        end else begin
          mask = 4'b1110;
          flg  = '{n: top_bit, v: next_bit, z: and_zero, c: 1'b0};
        end
      end
      OP_TSB, OP_TRB: begin
        res = lres; wr = 1'b1; mask = 4'b0010;
        flg = '{n: 1'b0, v: 1'b0, z: and_zero, c: 1'b0};
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu_stage.sv
module acc_alu_stage #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [PW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [PW-1:0] m_data
);
  logic          full_q;
  logic [PW-1:0] data_q;

  assign s_ready = !full_q || m_ready;
  assign m_valid = full_q;
  assign m_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) full_q <= 1'b0;
    else if (s_ready) full_q <= s_valid;
  end

  always_ff @(posedge clk) begin
    if (s_valid && s_ready) data_q <= s_data;
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [4:0]   in_op,
  input  logic [W-1:0] in_acc,
  input  logic [W-1:0] in_acc_hi,
  input  logic [W-1:0] in_opnd,
  input  logic         in_carry,
  input  logic         in_imm,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_res,
  output logic [W-1:0] out_res_hi,
  output logic         out_n,
  output logic         out_v,
  output logic         out_z,
  output logic         out_c,
  output logic [3:0]   out_mask,
  output logic         out_wr
);
  localparam int PW = 2 * W + 4 + 4 + 1;

  alu_op_e      op;
  logic [W-1:0] sum, lres, sres, shi, res, res_hi;
  logic         cout, ovf, and_zero, top_bit, next_bit, sc, wr;
  flags_t       flg;
  logic [3:0]   mask;
  logic [PW-1:0] pay_d, pay_q;

  assign op = alu_op_e'(in_op);

  acc_alu_arith #(.W(W)) u_arith (
    .op(op), .a(in_acc), .m(in_opnd), .cin(in_carry),
    .sum(sum), .cout(cout), .ovf(ovf)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .op(op), .a(in_acc), .m(in_opnd), .lres(lres),
    .and_zero(and_zero), .top_bit(top_bit), .next_bit(next_bit)
  );

  acc_alu_shift #(.W(W)) u_shift (
    .op(op), .a(in_acc), .hi(in_acc_hi), .cin(in_carry),
    .sres(sres), .shi(shi), .sc(sc)
  );

  acc_alu_flags #(.W(W)) u_flags (
    .op(op), .imm(in_imm), .a(in_acc), .hi(in_acc_hi),
    .sum(sum), .cout(cout), .ovf(ovf),
    .lres(lres), .and_zero(and_zero), .top_bit(top_bit), .next_bit(next_bit),
    .sres(sres), .shi(shi), .sc(sc),
    .res(res), .res_hi(res_hi), .flg(flg), .mask(mask), .wr(wr)
  );

  assign pay_d = {res, res_hi, flg, mask, wr};

  acc_alu_stage #(.PW(PW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .s_valid(in_valid), .s_ready(in_ready), .s_data(pay_d),
    .m_valid(out_valid), .m_ready(out_ready), .m_data(pay_q)
  );

  assign {out_res, out_res_hi, out_n, out_v, out_z, out_c, out_mask, out_wr} = pay_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [4:0]   in_op,
  input logic         in_imm,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_res,
  input logic [W-1:0] out_res_hi,
  input logic         out_n,
  input logic         out_v,
  input logic         out_z,
  input logic         out_c,
  input logic [3:0]   out_mask,
  input logic         out_wr
);
  logic [4:0] op_q;
  logic       imm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= '0;
      imm_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      op_q  <= in_op;
      imm_q <= in_imm;
    end
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_res_hi)
      && $stable({out_n, out_v, out_z, out_c}) && $stable(out_mask) && $stable(out_wr));

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_logic_nz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (op_q == 5'd3 || op_q == 5'd4 || op_q == 5'd5)
      |-> out_z == (out_res == '0) && out_n == out_res[W-1] && out_mask == 4'b1010);

  p_bit_imm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q == 5'd10 && imm_q |-> out_mask == 4'b0010 && !out_wr);

  p_tsb_z_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (op_q == 5'd14 || op_q == 5'd15) |-> out_mask == 4'b0010 && out_wr);

  p_cmp_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q == 5'd11 |-> !out_wr && out_mask == 4'b1011);

  p_unmasked_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({out_n, out_v, out_z, out_c} & ~out_mask) == 4'b0000);

  p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (op_q == 5'd0 || op_q > 5'd16) |-> out_mask == 4'b0000 && !out_wr);

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_acc_alu_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_imm(in_imm), .out_valid(out_valid), .out_ready(out_ready),
  .out_res(out_res), .out_res_hi(out_res_hi), .out_n(out_n), .out_v(out_v),
  .out_z(out_z), .out_c(out_c), .out_mask(out_mask), .out_wr(out_wr)
);

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ready;
  logic [4:0] in_op = '0;
  logic [7:0] in_acc = '0, in_acc_hi = '0, in_opnd = '0;
  logic       in_carry = 1'b0, in_imm = 1'b0;
  logic       out_valid, out_ready = 1'b0;
  logic [7:0] out_res, out_res_hi;
  logic       out_n, out_v, out_z, out_c, out_wr;
  logic [3:0] out_mask;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct { int op, a, hi, m, c, imm; } stim_t;
  typedef struct { int op, r, rh, fl, mk, wr; } exp_t;

  stim_t dq[$];
  exp_t  q[$];

  always #4 clk = ~clk;

  acc_alu i_acc_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_acc(in_acc), .in_acc_hi(in_acc_hi), .in_opnd(in_opnd),
    .in_carry(in_carry), .in_imm(in_imm), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_res_hi(out_res_hi), .out_n(out_n), .out_v(out_v),
    .out_z(out_z), .out_c(out_c), .out_mask(out_mask), .out_wr(out_wr)
  );

  function automatic string req_of(int op);
    case (op)
      1, 2:           return "R2";
      3, 4, 5:        return "R3";
      6, 7, 8, 9:     return "R4";
      10:             return "R5";
      14, 15:         return "R6";
      11:             return "R7";
      12, 13:         return "R8";
      16:             return "R9";
      default:        return "R10";
    endcase
  endfunction

  // Behavioural reference written from the requirements.
  function automatic exp_t model(stim_t s);
    exp_t e;
    int sum, r, n, v, z, c, mk, wr, rh, mm;
    r = s.a; rh = s.hi; n = 0; v = 0; z = 0; c = 0; mk = 0; wr = 0;
    case (s.op)
      1, 2: begin                                           // R2
        mm  = (s.op == 1) ? s.m : 255 - s.m;
        sum = s.a + mm + s.c;
        r = sum % 256; c = sum / 256;
        v = (((s.a ^ mm) & 128) == 0 && ((s.a ^ r) & 128) != 0) ? 1 : 0;
        mk = 15; wr = 1;
      end
      3: begin r = s.a & s.m; mk = 10; wr = 1; end          // R3
      4: begin r = s.a ^ s.m; mk = 10; wr = 1; end
      5: begin r = s.a | s.m; mk = 10; wr = 1; end
      6: begin c = s.a / 128; r = (s.a * 2) % 256; mk = 11; wr = 1; end   // R4
      7: begin c = s.a % 2;   r = s.a / 2;         mk = 11; wr = 1; end
      8: begin c = s.a / 128; r = (s.a * 2) % 256 + s.c; mk = 11; wr = 1; end
      9: begin c = s.a % 2;   r = s.a / 2 + s.c * 128;    mk = 11; wr = 1; end
      10: begin                                              // R5
        if (s.imm != 0) mk = 2;
        else begin mk = 14; n = s.m / 128; v = (s.m / 64) % 2; end
      end
      11: begin                                              // R7
        sum = s.a + (255 - s.m) + 1; r = sum % 256; c = sum / 256; mk = 11;
      end
      12: begin r = (s.a + 1) % 256;   mk = 10; wr = 1; end  // R8
      13: begin r = (s.a + 255) % 256; mk = 10; wr = 1; end
      14: begin r = s.m | s.a;          mk = 2; wr = 1; end  // R6
      15: begin r = s.m & (255 - s.a);  mk = 2; wr = 1; end
      16: begin r = s.hi; rh = s.a; mk = 10; wr = 1; end     // R9
      default: ;                                             // R10
    endcase
    if (s.op != 10) begin
      n = (mk / 8 != 0) ? r / 128 : 0;
      z = (r == 0) ? 1 : 0;
    end
    if (s.op == 10 || s.op == 14 || s.op == 15) z = ((s.a & s.m) == 0) ? 1 : 0;
    e.op = s.op; e.r = r; e.rh = rh; e.mk = mk; e.wr = wr;
    e.fl = (n * 8 + v * 4 + z * 2 + c) & mk;                 // R10 masking
    return e;
  endfunction

  task automatic add(int op, int a, int hi, int m, int c, int imm);
    stim_t s;
    s.op = op; s.a = a; s.hi = hi; s.m = m; s.c = c; s.imm = imm;
    dq.push_back(s);
  endtask

  task automatic check_cycle();
    n_vec++;
    if (out_valid !== (q.size() != 0)) begin
      n_bad++;
      $display("FAIL R1 out_valid actual %0b expected %0b", out_valid, q.size() != 0);
    end
    if (out_valid === 1'b1 && q.size() != 0) begin
      exp_t e;
      int fl;
      e  = q[0];
      fl = {28'd0, out_n, out_v, out_z, out_c};
      n_vec++;
      if (out_res != e.r[7:0] || out_res_hi != e.rh[7:0] || fl != e.fl
          || out_mask != e.mk[3:0] || out_wr != e.wr[0]) begin
        n_bad++;
        $display("FAIL %s op=%0d actual res=%02h hi=%02h fl=%b mask=%b wr=%b expected res=%02h hi=%02h fl=%b mask=%b wr=%0d",
                 req_of(e.op), e.op, out_res, out_res_hi, fl[3:0], out_mask, out_wr,
                 e.r[7:0], e.rh[7:0], e.fl[3:0], e.mk[3:0], e.wr);
      end
    end
  endtask

  initial begin
    // Directed corners
    add(1, 8'h7F, 0, 8'h01, 0, 0);   // R2 signed overflow
    add(1, 8'hFF, 0, 8'h01, 0, 0);   // R2 carry, zero
    add(2, 8'h80, 0, 8'h01, 1, 0);   // R2 overflow on subtract
    add(2, 8'h00, 0, 8'h01, 0, 0);   // R2 borrow
    add(3, 8'hF0, 0, 8'h0F, 0, 0);   // R3 zero
    add(4, 8'hAA, 0, 8'h2A, 0, 0);   // R3 negative
    add(6, 8'h80, 0, 8'h00, 0, 0);   // R4 carry out, zero
    add(8, 8'h80, 0, 8'h00, 1, 0);   // R4 rotate carry in
    add(9, 8'h01, 0, 8'h00, 1, 0);   // R4 rotate right
    add(7, 8'h01, 0, 8'h00, 1, 0);   // R4 logical right ignores carry
    add(10, 8'h01, 0, 8'hC2, 0, 0);  // R5 memory mode
    add(10, 8'h01, 0, 8'hC2, 0, 1);  // R5 immediate narrows to Z
    add(11, 8'h42, 0, 8'h42, 0, 0);  // R7 equal
    add(11, 8'h10, 0, 8'h20, 1, 0);  // R7 less than
    add(12, 8'hFF, 0, 8'h00, 0, 0);  // R8 wrap to zero
    add(13, 8'h00, 0, 8'h00, 0, 0);  // R8 wrap to FF
    add(14, 8'h0C, 0, 8'h03, 0, 0);  // R6 set, Z from pre-value
    add(15, 8'h0C, 0, 8'h0F, 0, 0);  // R6 reset
    add(16, 8'h5A, 8'h00, 8'h00, 0, 0); // R9 exchange to zero
    add(0, 8'h33, 8'h44, 8'h55, 1, 0);  // R10 no operation
    add(31, 8'h33, 8'h44, 8'h55, 1, 1); // R10 unused code

    // R11: reset state
    repeat (3) begin
      @(negedge clk);
      n_vec++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
        n_bad++;
        $display("FAIL R11 out_valid/in_ready actual %b%b expected 01", out_valid, in_ready);
      end
    end
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 3400; cyc++) begin
      bit from_dir;
      stim_t s;
      @(negedge clk);
      check_cycle();
      from_dir = 0;
      if (dq.size() != 0) begin
        s = dq[0]; from_dir = 1;
        in_valid = 1'b1; out_ready = 1'b1;
      end else if (cyc < 3300) begin
        s.op = $urandom_range(0, 20); s.a = $urandom_range(0, 255);
        s.hi = $urandom_range(0, 255); s.m = $urandom_range(0, 255);
        s.c = $urandom_range(0, 1); s.imm = $urandom_range(0, 1);
        in_valid  = ($urandom_range(0, 3) != 0);
        out_ready = ($urandom_range(0, 2) != 0);
      end else begin
        s = '{0, 0, 0, 0, 0, 0};
        in_valid = 1'b0; out_ready = 1'b1;
      end
      in_op = s.op[4:0]; in_acc = s.a[7:0]; in_acc_hi = s.hi[7:0];
      in_opnd = s.m[7:0]; in_carry = s.c[0]; in_imm = s.imm[0];
      #1;
      if (out_valid && out_ready) void'(q.pop_front());
      if (in_valid && in_ready) begin
        q.push_back(model(s));
        if (from_dir) void'(dq.pop_front());
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule